// File: doc/BRIEF.md
# Programmable Memory Region Guard

This block checks every memory access against a small table of programmable address regions and decides whether the access is allowed. Each region has a power-of-two size, a base address that is forced down to that size's alignment, eight equally sized slices that can each be removed from the match, an enable and a permission code. An access reports whether it matched a region, which region won, and whether it is refused.

Software programs the table through a simple register port: a control register, a region-select register, and a base and an attribute register that act on the selected region. The access-check path is purely combinational: address, privilege level and direction go in, and hit, region index and fault come out in the same cycle. When no region matches, an optional background map lets privileged accesses through, while unprivileged accesses are refused.

Top module: `region_guard`

## Requirements
- R1: The attribute register (offset 3) holds enable in bit 0, SIZE in bits [5:1], the slice-disable mask in bits [15:8] and the permission code in bits [18:16], with all other bits reading zero. A region spans 2^(SIZE+1) bytes. A written SIZE below 4 is stored and read back as 4.
- R2: The base register (offset 2) stores only address bits [31:SIZE+1] of the selected region. All lower bits read back as zero, and writes to them are lost.
- R3: An unaligned base is rounded down. With SIZE 17 and base 0x20010000, the region covers exactly 0x20000000 to 0x2003FFFF.
- R4: Each region is cut into eight equal slices. Mask bit i removes slice i, counted from the region base. A 512 KB region at 0x20000000 with mask 0xE1 matches only 0x20010000 to 0x2004FFFF.
- R5: For SIZE below 7 (regions under 256 bytes), the slice-disable mask has no effect and the whole region matches.
- R6: When several enabled regions match, the highest-numbered region provides the index and the permission.
- R7: Control register (offset 0) bit 0 is the global enable and bit 1 is the background enable. When both are set, a privileged access that matches no region passes with hit low and no fault.
- R8: With the global enable set, an access that matches no region faults unless R7 applies. In particular, every unprivileged miss faults.
- R9: Permission codes are 0 = no access, 1 = privileged read/write, 2 = privileged read/write plus user read, 3 = all read/write, 5 = privileged read, 6 = read for all, and 4 and 7 = no access. A matched access the code does not allow reports hit with a fault.
- R10: While the global enable is clear, every access reports hit low, index 0 and no fault.
- R11: A region whose enable bit is clear never matches.
- R12: After reset, the control and select registers read 0, every region is disabled with SIZE 4 (attribute reads 0x8) and base 0, and accesses pass unchecked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register offset: 0 control, 1 select, 2 base, 3 attribute |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| chk_addr | input | 32 | Address of the access under check |
| chk_priv | input | 1 | Access is privileged |
| chk_write | input | 1 | Access is a write |
| chk_hit | output | 1 | Access matched an enabled region |
| chk_region | output | 3 | Index of the winning region (0 when no hit) |
| chk_fault | output | 1 | Access is refused |

## Verification
Accesses are placed just inside and just outside each region edge, so that a base which is masked wrongly or a size that is off by one shows up as a moved boundary. Slice tests probe the first and last byte of enabled and removed slices, and they repeat this with small regions where the mask must be ignored. Overlapping regions with conflicting permissions separate the winner chosen by index from the first one found. Every permission code is tried with all four privilege and direction combinations that matter, and misses are tried with the background map on and off, so that refusal by permission, refusal by miss and a background pass can each be told apart.

// File: rtl/rg_pkg.sv
package rg_pkg;

    localparam int ADDR_W   = 32;
    localparam int BASE_LSB = 5;
    localparam int BASE_W   = ADDR_W - BASE_LSB;

    localparam logic [4:0] SIZE_MIN     = 5'd4;
    localparam logic [4:0] SLICE_MIN_SZ = 5'd7;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_SEL  = 2'd1,
        REG_BASE = 2'd2,
        REG_ATTR = 2'd3
    } reg_off_e;

    localparam logic [2:0] AP_PRIV_RW      = 3'd1;
    localparam logic [2:0] AP_PRIV_RW_U_RO = 3'd2;
    localparam logic [2:0] AP_ALL_RW       = 3'd3;
    localparam logic [2:0] AP_PRIV_RO      = 3'd5;
    localparam logic [2:0] AP_ALL_RO       = 3'd6;

    typedef struct packed {
        logic              en;
        logic [4:0]        size;
        logic [7:0]        slice_off;
        logic [2:0]        perm;
        logic [BASE_W-1:0] base;
    } region_cfg_t;

    // Mask that keeps the address bits above the region span
    function automatic logic [ADDR_W-1:0] span_mask(input logic [4:0] size);
        logic [ADDR_W:0] span;
        span = (33'd1 << ({1'b0, size} + 6'd1)) - 33'd1;
        return ~span[ADDR_W-1:0];
    endfunction

    // Which eighth of the region an address falls in
    function automatic logic [2:0] slice_of(input logic [ADDR_W-1:0] addr,
                                            input logic [4:0] size);
        logic [ADDR_W-1:0] shifted;
        shifted = addr >> (size - 5'd2);
        return shifted[2:0];
    endfunction

    function automatic logic access_allowed(input logic [2:0] perm,
                                            input logic priv,
                                            input logic wr);
        case (perm)
            AP_PRIV_RW:      return priv;
            AP_PRIV_RW_U_RO: return priv || !wr;
            AP_ALL_RW:       return 1'b1;
            AP_PRIV_RO:      return priv && !wr;
            AP_ALL_RO:       return !wr;
            default:         return 1'b0;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] attr_word(input region_cfg_t c);
        return {13'b0, c.perm, c.slice_off, 2'b0, c.size, c.en};
    endfunction

endpackage

// File: rtl/rg_regs.sv
module rg_regs
    import rg_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cfg_we,
    input  logic [1:0]                         cfg_addr,
    input  logic [ADDR_W-1:0]                  cfg_wdata,
    output logic [ADDR_W-1:0]                  cfg_rdata,
    output logic                               ctrl_en,
    output logic                               ctrl_bg,
    output logic [IDX_W-1:0]                   region_sel,
    output region_cfg_t [NUM_REGIONS-1:0]      region_cfg
);

    region_cfg_t       sel_cfg;
    logic [ADDR_W-1:0] base_wr;
    logic [4:0]        size_wr;

    assign sel_cfg = region_cfg[region_sel];
    assign base_wr = cfg_wdata & span_mask(sel_cfg.size);
    assign size_wr = (cfg_wdata[5:1] < SIZE_MIN) ? SIZE_MIN : cfg_wdata[5:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en    <= 1'b0;
            ctrl_bg    <= 1'b0;
            region_sel <= '0;
            for (int i = 0; i < NUM_REGIONS; i++) begin
                region_cfg[i] <= '{en: 1'b0, size: SIZE_MIN, slice_off: 8'h00,
                                   perm: 3'd0, base: '0};
            end
        end else if (cfg_we) begin
            case (reg_off_e'(cfg_addr))
                REG_CTRL: begin
                    ctrl_en <= cfg_wdata[0];
                    ctrl_bg <= cfg_wdata[1];
                end
                REG_SEL:  region_sel <= cfg_wdata[IDX_W-1:0];
                REG_BASE: region_cfg[region_sel].base <= base_wr[ADDR_W-1:BASE_LSB];
                REG_ATTR: begin
                    region_cfg[region_sel].en        <= cfg_wdata[0];
                    region_cfg[region_sel].size      <= size_wr;
                    region_cfg[region_sel].slice_off <= cfg_wdata[15:8];
                    region_cfg[region_sel].perm      <= cfg_wdata[18:16];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_off_e'(cfg_addr))
            REG_CTRL: cfg_rdata = {30'b0, ctrl_bg, ctrl_en};
            REG_SEL:  cfg_rdata = ADDR_W'(region_sel);
            REG_BASE: cfg_rdata = {sel_cfg.base, {BASE_LSB{1'b0}}} & span_mask(sel_cfg.size);
            default:  cfg_rdata = attr_word(sel_cfg);
        endcase
    end

endmodule

// File: rtl/rg_region_match.sv
module rg_region_match
    import rg_pkg::*;
(
    input  region_cfg_t       cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              match
);

    logic [ADDR_W-1:0] mask;
    logic              in_span;
    logic [2:0]        slice;
    logic              carved;

    always_comb begin
        mask    = span_mask(cfg.size);
        in_span = (addr & mask) == ({cfg.base, {BASE_LSB{1'b0}}} & mask);
        slice   = slice_of(addr, cfg.size);
        carved  = (cfg.size >= SLICE_MIN_SZ) && cfg.slice_off[slice];
        match   = cfg.en && in_span && !carved;
    end

endmodule

// File: rtl/rg_resolve.sv
module rg_resolve
    import rg_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic [NUM_REGIONS-1:0]         match_vec,
    input  region_cfg_t [NUM_REGIONS-1:0]  region_cfg,
    input  logic                           ctrl_en,
    input  logic                           ctrl_bg,
    input  logic                           chk_priv,
    input  logic                           chk_write,
    output logic                           chk_hit,
    output logic [IDX_W-1:0]               chk_region,
    output logic                           chk_fault
);

    logic             any_match;
    logic [IDX_W-1:0] winner;
    logic             allowed;

    // Later (higher-numbered) matches overwrite earlier ones
    always_comb begin
        any_match = 1'b0;
        winner    = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (match_vec[i]) begin
                any_match = 1'b1;
                winner    = IDX_W'(i);
            end
        end
    end

    assign allowed = access_allowed(region_cfg[winner].perm, chk_priv, chk_write);

    always_comb begin
        if (!ctrl_en) begin
            chk_hit    = 1'b0;
            chk_region = '0;
            chk_fault  = 1'b0;
        end else if (any_match) begin
            chk_hit    = 1'b1;
            chk_region = winner;
            chk_fault  = !allowed;
        end else begin
            chk_hit    = 1'b0;
            chk_region = '0;
            chk_fault  = !(ctrl_bg && chk_priv);
        end
    end

endmodule

// File: rtl/region_guard.sv
module region_guard
    import rg_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [31:0]       chk_addr,
    input  logic              chk_priv,
    input  logic              chk_write,
    output logic              chk_hit,
    output logic [IDX_W-1:0]  chk_region,
    output logic              chk_fault
);

    logic                          ctrl_en;
    logic                          ctrl_bg;
    logic [IDX_W-1:0]              region_sel;
    region_cfg_t [NUM_REGIONS-1:0] region_cfg;
    logic [NUM_REGIONS-1:0]        match_vec;

    rg_regs #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .ctrl_en    (ctrl_en),
        .ctrl_bg    (ctrl_bg),
        .region_sel (region_sel),
        .region_cfg (region_cfg)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        rg_region_match u_match (
            .cfg   (region_cfg[g]),
            .addr  (chk_addr),
            .match (match_vec[g])
        );
    end

    rg_resolve #(.NUM_REGIONS(NUM_REGIONS)) u_resolve (
        .match_vec  (match_vec),
        .region_cfg (region_cfg),
        .ctrl_en    (ctrl_en),
        .ctrl_bg    (ctrl_bg),
        .chk_priv   (chk_priv),
        .chk_write  (chk_write),
        .chk_hit    (chk_hit),
        .chk_region (chk_region),
        .chk_fault  (chk_fault)
    );

endmodule

// File: rtl/rg_checker.sv
module rg_checker
    import rg_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [1:0]                    cfg_addr,
    input  logic [31:0]                   cfg_wdata,
    input  logic [31:0]                   cfg_rdata,
    input  logic                          chk_priv,
    input  logic                          chk_hit,
    input  logic [IDX_W-1:0]              chk_region,
    input  logic                          chk_fault,
    input  logic                          ctrl_en,
    input  logic                          ctrl_bg,
    input  logic [IDX_W-1:0]              region_sel,
    input  region_cfg_t [NUM_REGIONS-1:0] region_cfg
);

    // R10: a disabled unit stays silent
    assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |-> (!chk_hit && !chk_fault && chk_region == '0));

    // R2: base read-back never exposes bits below the region span
    assert_base_lowbits_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == 2'd2) |-> ((cfg_rdata & ~span_mask(region_cfg[region_sel].size)) == '0));

    // R1: stored size never drops below the minimum
    assert_size_floor_R1: assert property (@(posedge clk) disable iff (rst)
        region_cfg[region_sel].size >= SIZE_MIN);

    // R7: privileged miss with background enabled passes
    assert_background_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_en && ctrl_bg && chk_priv && !chk_hit) |-> !chk_fault);

    // R8: unprivileged miss always faults while enabled
    assert_user_miss_faults_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_en && !chk_priv && !chk_hit) |-> chk_fault);

    // R11: a reported hit always names an enabled region
    assert_hit_enabled_R11: assert property (@(posedge clk) disable iff (rst)
        chk_hit |-> region_cfg[chk_region].en);

    // R7: a control write takes effect on the next cycle
    assert_ctrl_write_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 2'd0) |=> (ctrl_en == $past(cfg_wdata[0]) &&
                                          ctrl_bg == $past(cfg_wdata[1])));

endmodule

bind region_guard rg_checker #(.NUM_REGIONS(NUM_REGIONS)) u_rg_checker (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .chk_priv   (chk_priv),
    .chk_hit    (chk_hit),
    .chk_region (chk_region),
    .chk_fault  (chk_fault),
    .ctrl_en    (ctrl_en),
    .ctrl_bg    (ctrl_bg),
    .region_sel (region_sel),
    .region_cfg (region_cfg)
);

// File: tb/test_region_guard.sv
module test_region_guard;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [31:0] chk_addr;
    logic        chk_priv;
    logic        chk_write;
    logic        chk_hit;
    logic [2:0]  chk_region;
    logic        chk_fault;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    region_guard i_region_guard (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .chk_addr   (chk_addr),
        .chk_priv   (chk_priv),
        .chk_write  (chk_write),
        .chk_hit    (chk_hit),
        .chk_region (chk_region),
        .chk_fault  (chk_fault)
    );

    function automatic logic [31:0] attr(input logic en, input logic [4:0] size,
                                         input logic [7:0] off, input logic [2:0] perm);
        return {13'b0, perm, off, 2'b0, size, en};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_addr = a;
        #2;
        n_checks++;
        if (cfg_rdata !== exp) begin
            n_fails++;
            $display("FAIL %s: reg %0d read %h expected %h", req, a, cfg_rdata, exp);
        end
    endtask

    task automatic acc(input logic [31:0] a, input logic priv, input logic w,
                       input logic eh, input logic [2:0] er, input logic ef,
                       input string req);
        @(negedge clk);
        chk_addr  = a;
        chk_priv  = priv;
        chk_write = w;
        #2;
        n_checks++;
        if (chk_hit !== eh || chk_region !== er || chk_fault !== ef) begin
            n_fails++;
            $display("FAIL %s: addr %h priv %0b wr %0b got hit/reg/fault %0b/%0d/%0b expected %0b/%0d/%0b",
                     req, a, priv, w, chk_hit, chk_region, chk_fault, eh, er, ef);
        end
    endtask

    task automatic set_region(input int idx, input logic [31:0] base, input logic [4:0] size,
                              input logic [7:0] off, input logic [2:0] perm, input logic en);
        wr(2'd1, 32'(idx));
        wr(2'd3, attr(en, size, off, perm));
        wr(2'd2, base);
    endtask

    task automatic clear_all();
        for (int i = 0; i < 8; i++) set_region(i, 32'h0, 5'd4, 8'h00, 3'd0, 1'b0);
    endtask

    task automatic t_reset();
        rd_chk(2'd0, 32'h0, "R12");
        rd_chk(2'd1, 32'h0, "R12");
        rd_chk(2'd2, 32'h0, "R12");
        rd_chk(2'd3, 32'h8, "R12");
        acc(32'h0000_1234, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, "R12");
    endtask

    task automatic t_base_round();
        set_region(0, 32'h2001_0000, 5'd17, 8'h00, 3'd3, 1'b1);
        rd_chk(2'd2, 32'h2000_0000, "R2");
        wr(2'd2, 32'h2003_FFFF);
        rd_chk(2'd2, 32'h2000_0000, "R2");
        wr(2'd0, 32'h1);
        acc(32'h2000_0000, 1'b1, 1'b0, 1'b1, 3'd0, 1'b0, "R3");
        acc(32'h2003_FFFF, 1'b1, 1'b0, 1'b1, 3'd0, 1'b0, "R3");
        acc(32'h2004_0000, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, "R3");
        acc(32'h1FFF_FFFC, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, "R3");
    endtask

    task automatic t_size();
        clear_all();
        set_region(3, 32'h0000_0100, 5'd2, 8'h00, 3'd3, 1'b1);
        rd_chk(2'd3, attr(1'b1, 5'd4, 8'h00, 3'd3), "R1");
        rd_chk(2'd2, 32'h0000_0100, "R1");
        acc(32'h0000_011F, 1'b1, 1'b0, 1'b1, 3'd3, 1'b0, "R1");
        acc(32'h0000_0120, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, "R1");
        set_region(3, 32'h1234_5678, 5'd31, 8'h00, 3'd3, 1'b1);
        rd_chk(2'd2, 32'h0, "R2");
        acc(32'hFFFF_FFF0, 1'b1, 1'b1, 1'b1, 3'd3, 1'b0, "R1");
    endtask

    task automatic t_slices();
        clear_all();
        set_region(1, 32'h2000_0000, 5'd18, 8'hE1, 3'd3, 1'b1);
        acc(32'h2001_0000, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0, "R4");
        acc(32'h2004_FFFF, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0, "R4");
        acc(32'h2000_FFFF, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, "R4");
        acc(32'h2005_0000, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, "R4");
        acc(32'h2007_0004, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, "R4");
    endtask

    task automatic t_small_slices();
        clear_all();
        set_region(4, 32'h0000_0400, 5'd5, 8'hFF, 3'd3, 1'b1);
        acc(32'h0000_0400, 1'b1, 1'b0, 1'b1, 3'd4, 1'b0, "R5");
        acc(32'h0000_043F, 1'b1, 1'b0, 1'b1, 3'd4, 1'b0, "R5");
        set_region(4, 32'h0000_0400, 5'd6, 8'hFF, 3'd3, 1'b1);
        acc(32'h0000_047F, 1'b1, 1'b0, 1'b1, 3'd4, 1'b0, "R5");
        set_region(4, 32'h0000_0400, 5'd7, 8'h01, 3'd3, 1'b1);
        acc(32'h0000_0400, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, "R5");
        acc(32'h0000_0420, 1'b1, 1'b0, 1'b1, 3'd4, 1'b0, "R5");
    endtask

    task automatic t_priority();
        clear_all();
        set_region(2, 32'h0, 5'd31, 8'h00, 3'd3, 1'b1);
        set_region(5, 32'h0000_1000, 5'd11, 8'h00, 3'd6, 1'b1);
        set_region(1, 32'h0000_1000, 5'd11, 8'h00, 3'd0, 1'b1);
        acc(32'h0000_1000, 1'b1, 1'b1, 1'b1, 3'd5, 1'b1, "R6");
        acc(32'h0000_1000, 1'b1, 1'b0, 1'b1, 3'd5, 1'b0, "R6");
        acc(32'h0000_2000, 1'b1, 1'b1, 1'b1, 3'd2, 1'b0, "R6");
    endtask

    task automatic t_background();
        clear_all();
        wr(2'd0, 32'h3);
        rd_chk(2'd0, 32'h3, "R7");
        acc(32'h0000_5000, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, "R7");
        acc(32'h0000_5000, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, "R7");
        acc(32'h0000_5000, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, "R8");
        wr(2'd0, 32'h1);
        acc(32'h0000_5000, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, "R8");
    endtask

    task automatic t_perm();
        clear_all();
        set_region(0, 32'h0, 5'd31, 8'h00, 3'd2, 1'b1);
        acc(32'h0000_0040, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, "R9");
        acc(32'h0000_0040, 1'b0, 1'b1, 1'b1, 3'd0, 1'b1, "R9");
        acc(32'h0000_0040, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, "R9");
        set_region(0, 32'h0, 5'd31, 8'h00, 3'd0, 1'b1);
        acc(32'h0000_0040, 1'b1, 1'b0, 1'b1, 3'd0, 1'b1, "R9");
        set_region(0, 32'h0, 5'd31, 8'h00, 3'd1, 1'b1);
        acc(32'h0000_0040, 1'b0, 1'b0, 1'b1, 3'd0, 1'b1, "R9");
        acc(32'h0000_0040, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, "R9");
        set_region(0, 32'h0, 5'd31, 8'h00, 3'd5, 1'b1);
        acc(32'h0000_0040, 1'b1, 1'b1, 1'b1, 3'd0, 1'b1, "R9");
        acc(32'h0000_0040, 1'b1, 1'b0, 1'b1, 3'd0, 1'b0, "R9");
        set_region(0, 32'h0, 5'd31, 8'h00, 3'd6, 1'b1);
        acc(32'h0000_0040, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, "R9");
        acc(32'h0000_0040, 1'b0, 1'b1, 1'b1, 3'd0, 1'b1, "R9");
        set_region(0, 32'h0, 5'd31, 8'h00, 3'd7, 1'b1);
        acc(32'h0000_0040, 1'b1, 1'b0, 1'b1, 3'd0, 1'b1, "R9");
    endtask

    task automatic t_region_off();
        set_region(0, 32'h0, 5'd31, 8'h00, 3'd3, 1'b0);
        acc(32'h0000_0040, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, "R11");
    endtask

    task automatic t_global_off();
        set_region(6, 32'h0, 5'd31, 8'h00, 3'd0, 1'b1);
        wr(2'd0, 32'h0);
        rd_chk(2'd0, 32'h0, "R10");
        acc(32'h0000_0040, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, "R10");
        acc(32'hFFFF_FFFC, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, "R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        cfg_we    = 1'b0;
        cfg_addr  = 2'd0;
        cfg_wdata = 32'h0;
        chk_addr  = 32'h0;
        chk_priv  = 1'b0;
        chk_write = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_base_round();
        t_size();
        t_slices();
        t_small_slices();
        t_priority();
        t_background();
        t_perm();
        t_region_off();
        t_global_off();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule